// File: doc/BRIEF.md
# Serial Port Register Front End with Paced Interrupts

This block is the host-facing register set of a classic PC-style serial port. A CPU reaches it over a byte-wide bus with a 3-bit offset, a select strobe and a write flag. Each access takes one clock cycle. Read data is combinational from the offset during that cycle. Received characters come from an external source that presents a head byte and a non-empty flag, and that signals each new arrival with a one-cycle pulse. Transmitted characters leave on a one-cycle push strobe with the byte beside it. Serial framing, baud generation and FIFOs are handled elsewhere.

The block keeps a pending flag for receive and one for transmit, and drives one interrupt line that is the OR of the two. A raised interrupt is normally reported only after a programmable delay, so a host driver that drains characters in a tight loop is not starved. Two delay timers set the pace, one for receive and one for transmit. An age counter also records how long ago the last transmit interrupt was raised. When the transmit enable is written and that interrupt is old enough, the transmit interrupt is raised at once.

Top module: `serport_regs`

## Requirements
- R1: After reset the interrupt output is low, offsets 1, 3 and 4 read 0x00, offset 2 reads 0x01 (no interrupt) and offset 5 reads 0x60.
- R2: While bit 7 of the line-control byte (offset 3) is 1, offsets 0 and 1 form a divisor view: reads return 0x00, writes change nothing, no byte is pushed or popped, and no pending flag changes.
- R3: With bit 7 of line control clear, a read of offset 0 returns the head received byte, or 0x00 when the source is empty. It pops the byte when one is present and clears the receive pending flag. On the following clock, if the source still holds data and interrupt-enable bit 0 is set, the receive delay timer is started.
- R4: With bit 7 of line control clear, a write of offset 0 pushes the byte to the transmit sink and clears the transmit pending flag. If interrupt-enable bit 1 is set, it also starts the transmit delay timer.
- R5: Offset 2 reads 0x04 while receive is pending, else 0x02 while transmit is pending, else 0x01. A read that returns 0x02 clears the transmit pending flag. A read that returns 0x04 leaves both flags unchanged.
- R6: A delay timer started at clock edge t expires at edge t+DELAY. It sets its pending flag if the matching enable bit is still 1. Starting a running timer restarts the full interval.
- R7: A write to offset 1 with bit 1 set raises transmit pending on that edge when more than DELAY edges have passed since the last transmit interrupt (or since reset); otherwise it starts the transmit timer. A write with bit 1 clear stops that timer and clears transmit pending.
- R8: A write to offset 1 with bit 0 set while the source holds data starts the receive timer. Any other write to offset 1 stops the receive timer and clears receive pending.
- R9: Offset 5 reads bit 0 = receive data present, bits 5 and 6 = 1, all other bits 0. Offsets 6 and 7 read 0x00, and writes to offsets 5, 6 and 7 have no effect.
- R10: Offset 3 stores and returns a full byte. Writing 0x1A to offset 4 makes it read 0x9A, and every other value written there is ignored. Writes to offset 2 are ignored.
- R11: An arrival pulse while interrupt-enable bit 0 is set raises receive pending on that edge. With the bit clear, an arrival leaves the interrupt low.
- R12: The interrupt output equals receive pending OR transmit pending. A pending flag only rises while its enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for the current offset |
| rx_avail | input | 1 | Receive source holds at least one byte |
| rx_byte | input | 8 | Head byte of the receive source |
| rx_arrive | input | 1 | One-cycle pulse per newly arrived byte |
| rx_pop | output | 1 | Head byte consumed this cycle |
| tx_push | output | 1 | Byte handed to the transmit sink this cycle |
| tx_byte | output | 8 | Byte for the transmit sink |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DELAY = 12 instead of 450. This keeps every timer expiry, restart and cancellation inside a few dozen cycles. It also lets the test reach both outcomes of the transmit-enable age test within one short run: a write shortly after a transmit interrupt, and a write long after one. A behavioural model of the flags, timers and receive queue runs beside the design and is compared with the interrupt line on every cycle, and with the read data on every read.

// File: rtl/serport_pkg.sv
package serport_pkg;

   localparam int unsigned OFS_W  = 3;
   localparam int unsigned BYTE_W = 8;

   // Register offsets
   localparam logic [OFS_W-1:0] OFS_DATA  = 3'd0;
   localparam logic [OFS_W-1:0] OFS_ENA   = 3'd1;
   localparam logic [OFS_W-1:0] OFS_IDENT = 3'd2;
   localparam logic [OFS_W-1:0] OFS_LINE  = 3'd3;
   localparam logic [OFS_W-1:0] OFS_MODEM = 3'd4;
   localparam logic [OFS_W-1:0] OFS_STAT  = 3'd5;
   localparam logic [OFS_W-1:0] OFS_MSTAT = 3'd6;
   localparam logic [OFS_W-1:0] OFS_SPARE = 3'd7;

   // Identification codes
   localparam logic [BYTE_W-1:0] ID_RX   = 8'h04;
   localparam logic [BYTE_W-1:0] ID_TX   = 8'h02;
   localparam logic [BYTE_W-1:0] ID_NONE = 8'h01;

   // Bit positions
   localparam int unsigned ENA_RX_BIT = 0;
   localparam int unsigned ENA_TX_BIT = 1;
   localparam int unsigned LINE_DIV_BIT = 7;
   localparam int unsigned STAT_DR_BIT = 0;
   localparam int unsigned STAT_HE_BIT = 5;
   localparam int unsigned STAT_TE_BIT = 6;

   // Modem control loop request and stored value
   localparam logic [BYTE_W-1:0] MODEM_REQ = 8'h1A;
   localparam logic [BYTE_W-1:0] MODEM_VAL = 8'h9A;

   // Channel indices for the paced timers
   localparam int unsigned CH_RX = 0;
   localparam int unsigned CH_TX = 1;
   localparam int unsigned N_CH  = 2;

   typedef struct packed {
      logic data_rd;
      logic data_wr;
      logic ena_wr;
      logic ident_rd;
      logic line_wr;
      logic modem_wr;
   } access_t;

endpackage

// File: rtl/serport_decode.sv
module serport_decode
   import serport_pkg::*;
(
   input  logic             sel_i,
   input  logic             we_i,
   input  logic [OFS_W-1:0] addr_i,
   input  logic             div_view_i,
   output access_t          acc_o
);

   always_comb begin
      acc_o = '0;
      if (sel_i) begin
         case (addr_i)
            OFS_DATA: begin
               acc_o.data_rd = !we_i && !div_view_i;
               acc_o.data_wr =  we_i && !div_view_i;
            end
            OFS_ENA:   acc_o.ena_wr   = we_i && !div_view_i;
            OFS_IDENT: acc_o.ident_rd = !we_i;
            OFS_LINE:  acc_o.line_wr  = we_i;
            OFS_MODEM: acc_o.modem_wr = we_i;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/serport_delay_timer.sv
module serport_delay_timer #(
   parameter int unsigned DELAY = 450
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic cancel_i,
   output logic expire_o
);

   localparam int unsigned CNT_W = $clog2(DELAY + 1);

   if (DELAY < 2) begin : g_bad_delay
      $error("serport_delay_timer: DELAY must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   // Expiry is suppressed when the same edge restarts or stops the timer.
   assign expire_o = (cnt_q == CNT_W'(1)) && !arm_i && !cancel_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (cancel_i)         cnt_q <= '0;
      else if (arm_i)            cnt_q <= CNT_W'(DELAY);
      else if (cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
   end

endmodule

// File: rtl/serport_age.sv
module serport_age #(
   parameter int unsigned LIMIT = 450
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stamp_i,
   output logic aged_o
);

   localparam int unsigned AGE_W = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("serport_age: LIMIT must be at least 1");
   end

   logic [AGE_W-1:0] age_q;

   // age_q holds edges since the stamp minus one, saturating at LIMIT.
   assign aged_o = (age_q >= AGE_W'(LIMIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       age_q <= AGE_W'(LIMIT);
      else if (stamp_i)                 age_q <= '0;
      else if (age_q < AGE_W'(LIMIT))   age_q <= age_q + AGE_W'(1);
   end

endmodule

// File: rtl/serport_regs.sv
module serport_regs
   import serport_pkg::*;
#(
   parameter int unsigned DELAY = 450
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [OFS_W-1:0]  bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              rx_avail,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              rx_arrive,
   output logic              rx_pop,
   output logic              tx_push,
   output logic [BYTE_W-1:0] tx_byte,
   output logic              irq
);

   logic [BYTE_W-1:0] ena_q, line_q, modem_q;
   logic              rx_pend_q, tx_pend_q, recheck_q;
   logic              div_view;
   access_t           acc;

   logic [N_CH-1:0]   tmr_arm, tmr_cancel, tmr_expire;
   logic              tx_aged, tx_now;
   logic              rx_set, rx_clr, tx_set, tx_clr;

   assign div_view = line_q[LINE_DIV_BIT];

   serport_decode u_dec (
      .sel_i      (bus_sel),
      .we_i       (bus_we),
      .addr_i     (bus_addr),
      .div_view_i (div_view),
      .acc_o      (acc)
   );

   // Timer control
   assign tmr_arm[CH_RX]    = (recheck_q && ena_q[ENA_RX_BIT] && rx_avail)
                            || (acc.ena_wr && bus_wdata[ENA_RX_BIT] && rx_avail);
   assign tmr_cancel[CH_RX] = acc.ena_wr && !(bus_wdata[ENA_RX_BIT] && rx_avail);

   assign tx_now            = acc.ena_wr && bus_wdata[ENA_TX_BIT] && tx_aged;
   assign tmr_arm[CH_TX]    = (acc.data_wr && ena_q[ENA_TX_BIT])
                            || (acc.ena_wr && bus_wdata[ENA_TX_BIT] && !tx_aged);
   assign tmr_cancel[CH_TX] = acc.ena_wr && !bus_wdata[ENA_TX_BIT];

   for (genvar g = 0; g < N_CH; g++) begin : g_tmr
      serport_delay_timer #(.DELAY(DELAY)) u_tmr (
         .clk      (clk),
         .rst_n    (rst_n),
         .arm_i    (tmr_arm[g]),
         .cancel_i (tmr_cancel[g]),
         .expire_o (tmr_expire[g])
      );
   end

   serport_age #(.LIMIT(DELAY)) u_age (
      .clk     (clk),
      .rst_n   (rst_n),
      .stamp_i (tx_set),
      .aged_o  (tx_aged)
   );

   // Pending flag events
   assign rx_set = ena_q[ENA_RX_BIT] && (rx_arrive || tmr_expire[CH_RX]);
   assign rx_clr = acc.data_rd;
   assign tx_set = tx_now || (tmr_expire[CH_TX] && ena_q[ENA_TX_BIT]);
   assign tx_clr = acc.data_wr || (acc.ident_rd && !rx_pend_q && tx_pend_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_pend_q <= 1'b0;
         tx_pend_q <= 1'b0;
         recheck_q <= 1'b0;
      end else begin
         recheck_q <= acc.data_rd;
         if (tmr_cancel[CH_RX])  rx_pend_q <= 1'b0;
         else if (rx_set)        rx_pend_q <= 1'b1;
         else if (rx_clr)        rx_pend_q <= 1'b0;
         if (tmr_cancel[CH_TX])  tx_pend_q <= 1'b0;
         else if (tx_set)        tx_pend_q <= 1'b1;
         else if (tx_clr)        tx_pend_q <= 1'b0;
      end
   end

   // Control bytes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ena_q   <= '0;
         line_q  <= '0;
         modem_q <= '0;
      end else begin
         if (acc.ena_wr)  ena_q  <= bus_wdata;
         if (acc.line_wr) line_q <= bus_wdata;
         if (acc.modem_wr && bus_wdata == MODEM_REQ) modem_q <= MODEM_VAL;
      end
   end

   // Read path
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_DATA:  bus_rdata = (!div_view && rx_avail) ? rx_byte : '0;
         OFS_ENA:   bus_rdata = div_view ? '0 : ena_q;
         OFS_IDENT: bus_rdata = rx_pend_q ? ID_RX : (tx_pend_q ? ID_TX : ID_NONE);
         OFS_LINE:  bus_rdata = line_q;
         OFS_MODEM: bus_rdata = modem_q;
         OFS_STAT: begin
            bus_rdata[STAT_DR_BIT] = rx_avail;
            bus_rdata[STAT_HE_BIT] = 1'b1;
            bus_rdata[STAT_TE_BIT] = 1'b1;
         end
         default:   bus_rdata = '0;
      endcase
   end

   assign rx_pop  = acc.data_rd && rx_avail;
   assign tx_push = acc.data_wr;
   assign tx_byte = bus_wdata;
   assign irq     = rx_pend_q | tx_pend_q;

endmodule

// File: rtl/serport_regs_chk.sv
module serport_regs_chk
   import serport_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [OFS_W-1:0]  bus_addr,
   input logic [BYTE_W-1:0] bus_rdata,
   input logic              rx_avail,
   input logic              rx_arrive,
   input logic              tx_push,
   input logic [BYTE_W-1:0] ena_q,
   input logic [BYTE_W-1:0] line_q,
   input logic              rx_pend_q,
   input logic              tx_pend_q,
   input logic              rx_exp,
   input logic              tx_exp
);

   logic rd_acc;
   assign rd_acc = bus_sel && !bus_we;

   assert_data_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && bus_addr == OFS_DATA && !line_q[LINE_DIV_BIT] && !rx_arrive && !rx_exp)
      |=> !rx_pend_q);

   assert_push_clears_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push |=> !tx_pend_q);

   assert_ident_rx_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && bus_addr == OFS_IDENT && rx_pend_q) |-> bus_rdata == ID_RX);

   assert_ident_tx_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && bus_addr == OFS_IDENT && !rx_pend_q && tx_pend_q && !tx_exp)
      |=> !tx_pend_q);

   assert_status_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && bus_addr == OFS_STAT)
      |-> (bus_rdata[STAT_HE_BIT] && bus_rdata[STAT_TE_BIT]
           && bus_rdata[STAT_DR_BIT] == rx_avail));

   assert_rx_rise_enabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_pend_q) |-> ena_q[ENA_RX_BIT]);

   assert_tx_rise_enabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_pend_q) |-> ena_q[ENA_TX_BIT]);

endmodule

bind serport_regs serport_regs_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .rx_avail  (rx_avail),
   .rx_arrive (rx_arrive),
   .tx_push   (tx_push),
   .ena_q     (ena_q),
   .line_q    (line_q),
   .rx_pend_q (rx_pend_q),
   .tx_pend_q (tx_pend_q),
   .rx_exp    (tmr_expire[0]),
   .tx_exp    (tmr_expire[1])
);

// File: tb/serport_regs_tb_top.sv
module serport_regs_tb_top;

   localparam int DLY = 12;
   localparam int WATCHDOG = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_we = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       rx_avail = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       rx_arrive = 1'b0;
   logic [7:0] arr_byte = '0;
   logic       rx_pop, tx_push, irq;
   logic [7:0] tx_byte;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // 50 MHz clock: 20-unit period
   always #10 clk = ~clk;

   serport_regs #(.DELAY(DLY)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_avail(rx_avail), .rx_byte(rx_byte), .rx_arrive(rx_arrive),
      .rx_pop(rx_pop), .tx_push(tx_push), .tx_byte(tx_byte), .irq(irq)
   );

   // ---------------- behavioural reference model ----------------
   int         m_rxt, m_txt, m_age;
   bit         m_rxp, m_txp, m_rech;
   logic [7:0] m_ier, m_lcr, m_mcr;
   logic [7:0] rxq[$];
   int         tx_cnt;
   logic [7:0] tx_last;

   always @(posedge clk) begin : model
      bit av, dl, drd, dwr, iwr, ird, rarm, rcan, tarm, tcan, tnow, rexp, texp, rset, tset;
      if (!rst_n) begin
         m_rxt = 0; m_txt = 0; m_age = DLY;
         m_rxp = 0; m_txp = 0; m_rech = 0;
         m_ier = 0; m_lcr = 0; m_mcr = 0;
         rxq.delete();
         tx_cnt = 0; tx_last = 0;
      end else begin
         av  = rxq.size() > 0;
         dl  = m_lcr[7];
         drd = bus_sel && !bus_we && bus_addr == 0 && !dl;
         dwr = bus_sel &&  bus_we && bus_addr == 0 && !dl;
         iwr = bus_sel &&  bus_we && bus_addr == 1 && !dl;
         ird = bus_sel && !bus_we && bus_addr == 2;
         rarm = (m_rech && m_ier[0] && av) || (iwr && bus_wdata[0] && av);
         rcan = iwr && !(bus_wdata[0] && av);
         tnow = iwr && bus_wdata[1] && (m_age >= DLY);
         tarm = (dwr && m_ier[1]) || (iwr && bus_wdata[1] && (m_age < DLY));
         tcan = iwr && !bus_wdata[1];
         rexp = (m_rxt == 1) && !rarm && !rcan;
         texp = (m_txt == 1) && !tarm && !tcan;
         rset = m_ier[0] && (rx_arrive || rexp);
         tset = tnow || (texp && m_ier[1]);
         if (rcan) m_rxp = 0; else if (rset) m_rxp = 1; else if (drd) m_rxp = 0;
         if (tcan) m_txp = 0; else if (tset) m_txp = 1;
         else if (dwr || (ird && !m_rxp && m_txp)) m_txp = 0;
         m_rxt = rcan ? 0 : rarm ? DLY : (m_rxt > 0 ? m_rxt - 1 : 0);
         m_txt = tcan ? 0 : tarm ? DLY : (m_txt > 0 ? m_txt - 1 : 0);
         m_age = tset ? 0 : (m_age < DLY ? m_age + 1 : DLY);
         m_rech = drd;
         if (iwr) m_ier = bus_wdata;
         if (bus_sel && bus_we && bus_addr == 3) m_lcr = bus_wdata;
         if (bus_sel && bus_we && bus_addr == 4 && bus_wdata == 8'h1A) m_mcr = 8'h9A;
         if (rx_arrive) rxq.push_back(arr_byte);
         if (drd && av) void'(rxq.pop_front());
         if (tx_push) begin tx_cnt++; tx_last = tx_byte; end
      end
      rx_avail <= rxq.size() > 0;
      rx_byte  <= (rxq.size() > 0) ? rxq[0] : 8'h00;
   end

   function automatic logic [7:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return (!m_lcr[7] && rxq.size() > 0) ? rxq[0] : 8'h00;
         3'd1: return m_lcr[7] ? 8'h00 : m_ier;
         3'd2: return m_rxp ? 8'h04 : (m_txp ? 8'h02 : 8'h01);
         3'd3: return m_lcr;
         3'd4: return m_mcr;
         3'd5: return {1'b0, 2'b11, 4'b0000, rxq.size() > 0};
         default: return 8'h00;
      endcase
   endfunction

   // ---------------- checking helpers ----------------
   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   // Every cycle: interrupt line against the model (R12)
   always @(negedge clk) begin
      if (rst_n && !done) check8("R12 irq vs model", {7'b0, irq}, {7'b0, m_rxp | m_txp});
   end

   // Tasks start at a falling edge and consume exactly one rising edge.
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_we = 0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
      bus_sel = 1; bus_we = 0; bus_addr = a;
      #1;
      check8(tag, bus_rdata, exp);
      check8({tag, " vs model"}, bus_rdata, m_read(a));
      if (a == 3'd0)
         check8({tag, " pop"}, {7'b0, rx_pop}, {7'b0, (!m_lcr[7] && rxq.size() > 0)});
      @(negedge clk);
      bus_sel = 0;
   endtask

   task automatic arrive(input logic [7:0] b);
      rx_arrive = 1; arr_byte = b;
      @(negedge clk);
      rx_arrive = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      check8(tag, {7'b0, irq}, {7'b0, exp});
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin : stim
      int txc;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      chk_irq(0, "R1 irq");
      rd(3'd2, 8'h01, "R1 ident");
      rd(3'd5, 8'h60, "R1 status");
      rd(3'd1, 8'h00, "R1 enable");
      rd(3'd3, 8'h00, "R1 line");
      rd(3'd4, 8'h00, "R1 modem");

      // R10 line/modem/fifo-control, R9 spare registers
      wr(3'd3, 8'h03); rd(3'd3, 8'h03, "R10 line store");
      wr(3'd4, 8'h05); rd(3'd4, 8'h00, "R10 modem ignored");
      wr(3'd4, 8'h1A); rd(3'd4, 8'h9A, "R10 modem loop");
      wr(3'd2, 8'hFF); rd(3'd2, 8'h01, "R10 fifo write ignored");
      wr(3'd7, 8'h55); rd(3'd7, 8'h00, "R9 spare");
      wr(3'd5, 8'h00); rd(3'd5, 8'h60, "R9 status write ignored");
      rd(3'd6, 8'h00, "R9 modem status");

      // R7 immediate TX raise on enable (aged since reset)
      wr(3'd1, 8'h02); chk_irq(1, "R7 immediate");
      rd(3'd2, 8'h02, "R5 tx code"); chk_irq(0, "R5 tx cleared by ident");
      rd(3'd2, 8'h01, "R5 none");

      // R4 data write, R6 delay
      txc = tx_cnt;
      wr(3'd0, 8'h41);
      check8("R4 push count", 8'(tx_cnt - txc), 8'd1);
      check8("R4 push byte", tx_last, 8'h41);
      chk_irq(0, "R4 tx pending clear");
      idle(DLY - 1); chk_irq(0, "R6 before expiry");
      idle(1);       chk_irq(1, "R6 at expiry");

      // R6 restart
      rd(3'd2, 8'h02, "R5 tx code again");
      wr(3'd0, 8'h42); idle(5); wr(3'd0, 8'h43);
      idle(DLY - 1); chk_irq(0, "R6 restart not early");
      idle(1);       chk_irq(1, "R6 restart expiry");

      // R7 delayed when recent, clear cancels
      wr(3'd1, 8'h00); chk_irq(0, "R7 clear drops tx");
      wr(3'd1, 8'h02); chk_irq(0, "R7 recent -> delayed");
      idle(DLY - 1); chk_irq(0, "R7 delayed before expiry");
      idle(1);       chk_irq(1, "R7 delayed expiry");
      rd(3'd2, 8'h02, "R5 tx clear");
      wr(3'd0, 8'h44); idle(3); wr(3'd1, 8'h00);
      idle(DLY + 2); chk_irq(0, "R7 cancelled timer");
      wr(3'd1, 8'h02); chk_irq(1, "R7 aged -> immediate");
      wr(3'd1, 8'h00); chk_irq(0, "R7 clear");

      // R8, R11 receive side
      wr(3'd1, 8'h01); chk_irq(0, "R8 no data no arm");
      arrive(8'h5A); chk_irq(1, "R11 arrival raises");
      rd(3'd5, 8'h61, "R9 data ready");
      rd(3'd2, 8'h04, "R5 rx code");
      wr(3'd1, 8'h03);
      idle(DLY);
      rd(3'd2, 8'h04, "R5 rx over tx");
      rd(3'd0, 8'h5A, "R3 head byte");
      chk_irq(1, "R5 tx still pending");
      rd(3'd2, 8'h02, "R5 tx after rx");
      chk_irq(0, "R5 all clear");
      rd(3'd0, 8'h00, "R3 empty read");

      // R3 re-arm after read with data remaining
      arrive(8'h11); chk_irq(1, "R11 arrival");
      arrive(8'h22);
      rd(3'd0, 8'h11, "R3 first byte");
      chk_irq(0, "R3 rx cleared");
      idle(DLY);    chk_irq(0, "R3 rearm not early");
      idle(1);      chk_irq(1, "R3 rearm expiry");
      rd(3'd0, 8'h22, "R3 second byte");
      idle(DLY + 2); chk_irq(0, "R3 no rearm when empty");

      // R2 divisor view
      arrive(8'h33); chk_irq(1, "R11 arrival");
      txc = tx_cnt;
      wr(3'd3, 8'h83);
      wr(3'd0, 8'h77);
      check8("R2 no push", 8'(tx_cnt - txc), 8'd0);
      wr(3'd1, 8'h00);
      rd(3'd0, 8'h00, "R2 divisor low");
      rd(3'd1, 8'h00, "R2 divisor high");
      chk_irq(1, "R2 pending untouched");
      wr(3'd3, 8'h03);
      rd(3'd1, 8'h03, "R2 enable unchanged");
      rd(3'd0, 8'h33, "R2 byte not popped");

      // R8 arm on enable with data, R11 disabled arrival
      wr(3'd1, 8'h00);
      arrive(8'h44); chk_irq(0, "R11 disabled arrival");
      wr(3'd1, 8'h01);
      idle(DLY - 1); chk_irq(0, "R8 before expiry");
      idle(1);       chk_irq(1, "R8 expiry");
      wr(3'd1, 8'h00); chk_irq(0, "R8 clear drops rx");
      rd(3'd0, 8'h44, "R3 drain");

      done = 1;
      summary();
      $finish;
   end

endmodule